// File: doc/BRIEF.md
# Write-Activity Status Timer

This block watches a strobe that marks each write on an external bus and keeps a small set of deadlines, all stamped against a free-running tick count supplied from outside. A read strobe returns a 32-bit status word. Three bits of that word, positions 0, 4 and 5, are recomputed from the current tick and the stored deadlines. The other 29 bits come from a base register that the host may overwrite.

Bit 5 is a short "recently written" flag. Bit 4 turns on after a delay and stays on while writes keep arriving within its hold window. Bit 0 follows a slower on/off schedule that grows by one step for each write landing inside an active window.

When the tick count is seen below the timestamp of the last write, the counter has wrapped. The block then zeroes every deadline that lies beyond that timestamp, so no flag stays stuck. The read path and the strobes are plain control pins. A read has no back-pressure: its result appears on the next clock and holds until the next read.

Top module: `wr_activity_status`

## Requirements
- R1: Bit 5 of a read returns 1 when the read's tick t is below T+8, where T is the tick of the most recent write; otherwise it returns 0.
- R2: On a write at tick t, if the stored bit-4 off-deadline is below t, the bit-4 on-time becomes t+8; otherwise the on-time is kept.
- R3: On a write at tick t, the bit-4 off-deadline becomes max(t, previous off-deadline) + 16.
- R4: On a write at tick t, if the bit-0 off-deadline is below t, the bit-0 on-time becomes t+24 and the off-deadline becomes t+48; otherwise the off-deadline grows by 24 and the on-time is kept.
- R5: Bit 4 of a read at tick t is 1 only when the off-deadline is above t, the off-deadline is at most t+8 (compared without wrap), and the on-time is at most t; otherwise it is 0.
- R6: Bit 0 of a read at tick t is 1 when the on-time is at most t and the off-deadline is above t; otherwise it is 0.
- R7: In any cycle whose tick is below the last-write timestamp, every deadline greater than that timestamp is zeroed before that cycle's read evaluation and write update.
- R8: After reset, the timestamp, all deadlines and the base register are zero, so a read returns 32'h0.
- R9: Bits other than 0, 4 and 5 of a read equal the base register. A base write stores base_wdata_i from the next cycle on. Base bits 0, 4 and 5 never reach the output.
- R10: The status output takes the read result in the cycle after rd_stb_i and otherwise holds its value. A read in the same cycle as a write or a base write sees the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 32 | Free-running tick count |
| wr_stb_i | input | 1 | One bus write occurred this cycle |
| rd_stb_i | input | 1 | Sample the status word this cycle |
| rd_status_o | output | 32 | Status word from the last read |
| base_we_i | input | 1 | Load the base status register |
| base_wdata_i | input | 32 | New base status value |

## Verification
The hardest situation to reach is a tick count that falls below the last-write timestamp. Only that condition triggers the zeroing of deadlines, and only a counter wrap or a jump backward produces it. The bench drives the tick bus itself. It places a write a few ticks below the top of the 32-bit range, where some deadline sums already wrap, and then moves the tick back to a small value and reads several times. Random traffic adds occasional backward jumps of the tick on top of bursts of writes, so that stretched bit-0 windows and chained bit-4 holds meet the correction.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int NDL      = 5;
  localparam int DL_B5OFF = 0;
  localparam int DL_B4ON  = 1;
  localparam int DL_B4OFF = 2;
  localparam int DL_B0ON  = 3;
  localparam int DL_B0OFF = 4;

  localparam int POS_B0 = 0;
  localparam int POS_B4 = 4;
  localparam int POS_B5 = 5;
endpackage

// File: rtl/ws_wrap_fix.sv
module ws_wrap_fix
  import ws_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic [TW-1:0]          tick_i,
  input  logic [TW-1:0]          ts_i,
  input  logic [NDL-1:0][TW-1:0] dl_i,
  output logic [NDL-1:0][TW-1:0] dl_o,
  output logic                   wrap_o
);
  assign wrap_o = tick_i < ts_i;

  for (genvar g = 0; g < NDL; g++) begin : g_dl
    assign dl_o[g] = (wrap_o && (dl_i[g] > ts_i)) ? '0 : dl_i[g];
  end
endmodule

// File: rtl/ws_write_update.sv
module ws_write_update
  import ws_pkg::*;
#(
  parameter int TW        = 32,
  parameter int ACT_TICKS = 8,
  parameter int B4_HOLD   = 16,
  parameter int B0_STEP   = 24
) (
  input  logic [TW-1:0]          tick_i,
  input  logic [NDL-1:0][TW-1:0] dl_i,
  output logic [NDL-1:0][TW-1:0] dl_o
);
  localparam logic [TW-1:0] ACT_V  = TW'(ACT_TICKS);
  localparam logic [TW-1:0] HOLD_V = TW'(B4_HOLD);
  localparam logic [TW-1:0] STEP_V = TW'(B0_STEP);

  logic b4_lapsed, b0_lapsed;

  always_comb begin
    b4_lapsed = dl_i[DL_B4OFF] < tick_i;
    b0_lapsed = dl_i[DL_B0OFF] < tick_i;
    dl_o = dl_i;
    dl_o[DL_B5OFF] = tick_i + ACT_V;
    if (b4_lapsed) dl_o[DL_B4ON] = tick_i + ACT_V;
    dl_o[DL_B4OFF] = (b4_lapsed ? tick_i : dl_i[DL_B4OFF]) + HOLD_V;
    if (b0_lapsed) begin
      dl_o[DL_B0ON]  = tick_i + STEP_V;
      dl_o[DL_B0OFF] = tick_i + STEP_V + STEP_V;
    end else begin
      dl_o[DL_B0OFF] = dl_i[DL_B0OFF] + STEP_V;
    end
  end
endmodule

// File: rtl/ws_status_eval.sv
module ws_status_eval
  import ws_pkg::*;
#(
  parameter int TW        = 32,
  parameter int SW        = 32,
  parameter int ACT_TICKS = 8
) (
  input  logic [TW-1:0]          tick_i,
  input  logic [NDL-1:0][TW-1:0] dl_i,
  input  logic [SW-1:0]          base_i,
  output logic [SW-1:0]          status_o
);
  localparam logic [TW:0] ACT_X = (TW+1)'(ACT_TICKS);

  logic [TW:0] near_lim;
  logic        b4_far, b5, b4, b0;

  always_comb begin
    near_lim = {1'b0, tick_i} + ACT_X;
    b4_far   = {1'b0, dl_i[DL_B4OFF]} > near_lim;
    b5       = tick_i < dl_i[DL_B5OFF];
    b4       = (dl_i[DL_B4OFF] > tick_i) && !b4_far && (dl_i[DL_B4ON] <= tick_i);
    b0       = (dl_i[DL_B0OFF] > tick_i) && (dl_i[DL_B0ON] <= tick_i);
    status_o = base_i;
    status_o[POS_B0] = b0;
    status_o[POS_B4] = b4;
    status_o[POS_B5] = b5;
  end
endmodule

// File: rtl/wr_activity_status.sv
module wr_activity_status
  import ws_pkg::*;
#(
  parameter int TW        = 32,
  parameter int SW        = 32,
  parameter int ACT_TICKS = 8,
  parameter int B4_HOLD   = 16,
  parameter int B0_STEP   = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick_i,
  input  logic          wr_stb_i,
  input  logic          rd_stb_i,
  output logic [SW-1:0] rd_status_o,
  input  logic          base_we_i,
  input  logic [SW-1:0] base_wdata_i
);
  localparam logic [SW-1:0] OWN_MASK =
    (SW'(1) << POS_B0) | (SW'(1) << POS_B4) | (SW'(1) << POS_B5);

  logic [TW-1:0]          ts_q;
  logic [NDL-1:0][TW-1:0] dl_q, dl_fix, dl_wr;
  logic [SW-1:0]          base_q, status_now;
  logic                   wrap_now;

  ws_wrap_fix #(.TW(TW)) u_fix (
    .tick_i(tick_i), .ts_i(ts_q), .dl_i(dl_q), .dl_o(dl_fix), .wrap_o(wrap_now)
  );

  ws_write_update #(.TW(TW), .ACT_TICKS(ACT_TICKS), .B4_HOLD(B4_HOLD),
                    .B0_STEP(B0_STEP)) u_upd (
    .tick_i(tick_i), .dl_i(dl_fix), .dl_o(dl_wr)
  );

  ws_status_eval #(.TW(TW), .SW(SW), .ACT_TICKS(ACT_TICKS)) u_eval (
    .tick_i(tick_i), .dl_i(dl_fix), .base_i(base_q), .status_o(status_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q        <= '0;
      dl_q        <= '0;
      base_q      <= '0;
      rd_status_o <= '0;
    end else begin
      if (wr_stb_i) begin
        ts_q <= tick_i;
        dl_q <= dl_wr;
      end else begin
        dl_q <= dl_fix;
      end
      if (base_we_i) base_q <= base_wdata_i;
      if (rd_stb_i) rd_status_o <= status_now;
    end
  end

  // R10: output only moves on a read
  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_status_o));

  // R1: bit-5 deadline sits a fixed distance after the write stamp
  a_r1_b5_distance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i |=> (dl_q[DL_B5OFF] - ts_q) == TW'(ACT_TICKS));

  // R3: bit-4 off-deadline is at least one hold after the write stamp
  a_r3_b4_span: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i |=> (dl_q[DL_B4OFF] - ts_q) >= TW'(B4_HOLD));

  // R7: after a wrap cycle without a write, nothing lies past the stamp
  a_r7_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i < ts_q) && !wr_stb_i |=>
      (dl_q[DL_B5OFF] <= ts_q) && (dl_q[DL_B0OFF] <= ts_q) && (dl_q[DL_B4OFF] <= ts_q));

  // R9: base bits pass through untouched on a read
  a_r9_base_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> (rd_status_o & ~OWN_MASK) == ($past(base_q) & ~OWN_MASK));
endmodule

// File: tb/wr_activity_status_bench.sv
module wr_activity_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tick = '0;
  logic        wr = 1'b0, rd = 1'b0, bwe = 1'b0;
  logic [31:0] bdata = '0;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wr_activity_status u_wr_activity_status (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_stb_i(wr), .rd_stb_i(rd),
    .rd_status_o(status), .base_we_i(bwe), .base_wdata_i(bdata)
  );

  // bench model: 0 b5off, 1 b4on, 2 b4off, 3 b0on, 4 b0off
  logic [31:0] m_ts = '0, m_base = '0;
  logic [31:0] m_dl [5] = '{default: '0};

  task automatic m_fix(input logic [31:0] t);
    if (t < m_ts)
      for (int i = 0; i < 5; i++) if (m_dl[i] > m_ts) m_dl[i] = '0;
  endtask

  task automatic m_write(input logic [31:0] t);
    logic [31:0] off4;
    m_ts = t;
    m_dl[0] = t + 8;
    off4 = m_dl[2];
    if (off4 < t) m_dl[1] = t + 8;
    m_dl[2] = ((off4 > t) ? off4 : t) + 16;
    if (m_dl[4] < t) begin
      m_dl[3] = t + 24;
      m_dl[4] = t + 48;
    end else m_dl[4] = m_dl[4] + 24;
  endtask

  function automatic logic [31:0] m_eval(input logic [31:0] t);
    logic [31:0] s;
    logic [32:0] lim;
    s = m_base;
    lim = {1'b0, t} + 33'd8;
    s[5] = t < m_dl[0];
    s[4] = (m_dl[2] > t) && ({1'b0, m_dl[2]} <= lim) && (m_dl[1] <= t);
    s[0] = (m_dl[4] > t) && (m_dl[3] <= t);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic be,
                      input logic [31:0] bd, input logic [31:0] t, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    wr = w; rd = r; bwe = be; bdata = bd; tick = t;
    m_fix(t);
    exp = m_eval(t);
    if (w) m_write(t);
    @(posedge clk);
    #1;
    if (r) begin
      chk({tag, " R1 bit5"}, {31'b0, status[5]}, {31'b0, exp[5]});
      chk({tag, " R5 bit4"}, {31'b0, status[4]}, {31'b0, exp[4]});
      chk({tag, " R6 bit0"}, {31'b0, status[0]}, {31'b0, exp[0]});
      chk({tag, " R9 base"}, status & ~32'h31, exp & ~32'h31);
    end
    if (be) m_base = bd;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    step(0, 1, 0, 0, 32'd100, "R8");
    chk("R8 word", status, 32'h0);

    // R9: base write, own bits masked
    step(0, 0, 1, 32'hFFFF_FFFF, 32'd101, "R9");
    step(0, 1, 0, 0, 32'd102, "R9");
    chk("R9 word", status, 32'hFFFF_FFCE);
    step(0, 0, 1, 32'h0, 32'd103, "R9");

    // R2 R3 R4: single write then sweep
    step(1, 0, 0, 0, 32'd200, "R2");
    for (int k = 201; k < 262; k++) step(0, 1, 0, 0, k, "R2 R4 sweep");
    step(0, 1, 0, 0, 32'd207, "R1");
    chk("R1 inside window", {31'b0, status[5]}, 32'd1);
    step(0, 1, 0, 0, 32'd208, "R1");
    chk("R1 window edge", {31'b0, status[5]}, 32'd0);

    // R3 R4: burst of writes stretches windows
    step(1, 0, 0, 0, 32'd300, "R3");
    step(1, 0, 0, 0, 32'd302, "R3");
    step(1, 0, 0, 0, 32'd304, "R4");
    for (int k = 305; k < 420; k++) step(0, 1, 0, 0, k, "R3 R4 burst");

    // R10: read with write in same cycle sees old state, then holds
    step(1, 1, 0, 0, 32'd1000, "R10");
    chk("R10 same-cycle write", {31'b0, status[5]}, 32'd0);
    held = status;
    step(0, 0, 0, 0, 32'd1003, "R10");
    step(0, 0, 1, 32'hA5A5_0000, 32'd1004, "R10");
    chk("R10 hold", status, held);
    step(0, 1, 0, 0, 32'd1005, "R10");
    chk("R10 updated", {31'b0, status[5]}, 32'd1);

    // R7: write near top of range, then tick falls back
    step(1, 0, 0, 0, 32'hFFFF_FFF0, "R7");
    step(0, 1, 0, 0, 32'hFFFF_FFF2, "R7");
    chk("R7 before wrap", {31'b0, status[5]}, 32'd1);
    step(0, 1, 0, 0, 32'd5, "R7");
    chk("R7 after wrap bit5", {31'b0, status[5]}, 32'd0);
    for (int k = 6; k < 60; k++) step(0, 1, 0, 0, k, "R7 sweep");

    // random traffic
    cur = 32'd50000;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) cur = cur + ($urandom % 30);
      else cur = cur + 1;
      if ($urandom % 400 == 0) cur = cur - ($urandom % 200) - 1;
      step(($urandom % 6) == 0, ($urandom % 2) == 0, ($urandom % 50) == 0,
           $urandom, cur, "rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule